// File: doc/BRIEF.md
# Buffered Two-Wire Bus Repeater Switch

This block is a clocked, digital model of a one-to-four repeater for a two-wire bus whose lines are open-drain. One upstream clock/data pair fans out to four downstream clock/data pairs. Each physical line is represented by two signals: a level input that reports what the wire currently reads, and a pull output that, when 1, makes the block sink the wire low. The block never drives a wire high. Every level input passes through a two-flop synchronizer before any logic uses it.

The clock is repeated in one direction only, and one configuration bit chooses that direction. In the default direction, the upstream clock is copied onto every enabled downstream clock. In the reversed direction, the upstream clock is pulled low whenever any enabled downstream clock is low, which is the wired-AND of the enabled downstream clocks. A low level is never passed back against the chosen direction, so a slave cannot stretch the clock through the block. The data line is repeated in both directions. The port whose line falls first takes ownership. Lows arriving from the other side are ignored until the owner's line is seen high again.

An 8-bit configuration register is loaded through a simple parallel write strobe. Its low four bits enable the downstream channels, and its top bit reverses the clock. A disabled channel is never pulled and is invisible to arbitration and to the clock AND.

Top module: `bus_repeater_switch`

## Requirements
- R1: While `rst_n` is low, and afterwards until the first write, every pull output is 0 and the configuration register is 0. This means all channels are disabled and the clock runs in the default direction.
- R2: On a clock edge with `cfg_we` = 1, the register takes `cfg_wdata`. Bit k (k = 0..3) enables downstream channel k, and bit 7 = 1 reverses the clock direction.
- R3: In the default direction (bit 7 = 0), `dn_clk_pull[k]` is 1 exactly when channel k is enabled and the synchronized upstream clock reads low. `up_clk_pull` stays 0.
- R4: In the reversed direction (bit 7 = 1), `up_clk_pull` is 1 exactly when at least one enabled downstream clock reads low. Every `dn_clk_pull` stays 0, whatever the upstream clock does.
- R5: A disabled channel's clock pull and data pull are never asserted.
- R6: When the upstream data line falls first, the block pulls every enabled downstream data line low and does not pull the upstream data line.
- R7: When an enabled downstream data line k falls first, the block pulls the upstream data line low and pulls no downstream data line.
- R8: While a direction is held, falls on any other data port are ignored. When the owner releases, a port that is still low does not take over, because only a new fall can win.
- R9: The hold ends, and every data pull drops together, on the third clock edge after the owner's line goes high. The block does not capture ownership from the lines it was itself pulling low.
- R10: When several data ports fall in the same cycle, the upstream port wins. After it, downstream 0 beats 1, 1 beats 2, and 2 beats 3.
- R11: A fall on a disabled downstream data line never wins arbitration. In reversed mode, a low on a disabled downstream clock does not pull the upstream clock.
- R12: A change on a level input first shows on a pull output on the third rising clock edge after the change: two synchronizer edges plus one output register edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write value |
| up_clk_in | input | 1 | Upstream clock wire level |
| up_clk_pull | output | 1 | Sink upstream clock wire low |
| up_dat_in | input | 1 | Upstream data wire level |
| up_dat_pull | output | 1 | Sink upstream data wire low |
| dn_clk_in | input | 4 | Downstream clock wire levels, bit k = channel k |
| dn_clk_pull | output | 4 | Sink downstream clock wires low |
| dn_dat_in | input | 4 | Downstream data wire levels |
| dn_dat_pull | output | 4 | Sink downstream data wires low |

## Verification
The bench models every wire as a wired-AND of its external driver and the block's own pull. This exposes self-latching at release, which a bench that ignored the block's own drive would never see. Directed patterns separate the two directions by using falls that arrive one at a time, same-cycle falls, and a second port still low when the owner releases; each of these catches a different arbitration fault. Disabled-channel patterns on both clock and data tell masking apart from plain forwarding. A seeded random phase then toggles wires and rewrites the configuration, and the block is compared each cycle against a cycle-accurate bench model.

// File: rtl/brs_pkg.sv
`timescale 1ns/1ps
package brs_pkg;
    localparam int BRS_CFG_W  = 8;
    localparam int BRS_NUM_CH = 4;
    localparam int BRS_SYNC_N = 2;

    typedef enum logic [1:0] {
        SIDE_NONE = 2'd0,
        SIDE_UP   = 2'd1,
        SIDE_DN   = 2'd2
    } side_e;
endpackage

// File: rtl/brs_sync.sv
`timescale 1ns/1ps
module brs_sync #(
    parameter int WIDTH  = 10,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            pipe_d[s] = pipe_q[s-1];
        end
    end

    // Idle open-drain wires read high, so reset to ones.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= pipe_d;
    end

    assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/brs_clk_route.sv
`timescale 1ns/1ps
module brs_clk_route #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reverse,
    input  logic [NUM_CH-1:0] en,
    input  logic              up_lvl,
    input  logic [NUM_CH-1:0] dn_lvl,
    output logic              up_pull,
    output logic [NUM_CH-1:0] dn_pull
);
    typedef struct packed {
        logic              up_pull;
        logic [NUM_CH-1:0] dn_pull;
    } clk_st_t;

    clk_st_t st_d, st_q;

    always_comb begin
        st_d = '0;
        if (reverse) begin
            st_d.up_pull = |(en & ~dn_lvl);
        end else begin
            st_d.dn_pull = en & {NUM_CH{~up_lvl}};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign up_pull = st_q.up_pull;
    assign dn_pull = st_q.dn_pull;

    AST_CLK_ONE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
        !(up_pull && (|dn_pull))); // R4
    AST_CLK_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        ((dn_pull & ~$past(en)) == '0)); // R5
    AST_CLK_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        (!reverse && !up_lvl) |=> (dn_pull == $past(en))); // R3
endmodule

// File: rtl/brs_dat_arbiter.sv
`timescale 1ns/1ps
module brs_dat_arbiter
    import brs_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] en,
    input  logic              up_lvl,
    input  logic [NUM_CH-1:0] dn_lvl,
    output logic              up_pull,
    output logic [NUM_CH-1:0] dn_pull
);
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    typedef struct packed {
        side_e             side;
        logic [IDX_W-1:0]  idx;
        logic              up_prev;
        logic [NUM_CH-1:0] dn_prev;
        logic              up_pull;
        logic [NUM_CH-1:0] dn_pull;
    } arb_st_t;

    arb_st_t           st_d, st_q;
    logic              up_fall;
    logic [NUM_CH-1:0] dn_fall;
    logic              win_low;

    always_comb begin
        st_d         = st_q;
        st_d.up_prev = up_lvl;
        st_d.dn_prev = dn_lvl;
        up_fall      = st_q.up_prev & ~up_lvl;
        dn_fall      = st_q.dn_prev & ~dn_lvl & en;

        case (st_q.side)
            SIDE_UP: win_low = ~up_lvl;
            SIDE_DN: win_low = ~dn_lvl[st_q.idx] & en[st_q.idx];
            default: win_low = 1'b0;
        endcase

        if (st_q.side == SIDE_NONE) begin
            if (up_fall) begin
                st_d.side = SIDE_UP;
            end else begin
                // Descending scan: the lowest falling channel is written last.
                for (int k = NUM_CH - 1; k >= 0; k--) begin
                    if (dn_fall[k]) begin
                        st_d.side = SIDE_DN;
                        st_d.idx  = IDX_W'(k);
                    end
                end
            end
        end else if (!win_low) begin
            st_d.side = SIDE_NONE;
        end

        st_d.up_pull = (st_d.side == SIDE_DN);
        st_d.dn_pull = (st_d.side == SIDE_UP) ? en : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.up_prev <= 1'b1;
            st_q.dn_prev <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign up_pull = st_q.up_pull;
    assign dn_pull = st_q.dn_pull;

    AST_DAT_ONE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        !(up_pull && (|dn_pull))); // R6
    AST_DAT_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        ((dn_pull & ~$past(en)) == '0)); // R5
    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.side != SIDE_NONE && win_low)
        |=> (st_q.side == $past(st_q.side) && st_q.idx == $past(st_q.idx))); // R8
    AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.side != SIDE_NONE && !win_low) |=> (st_q.side == SIDE_NONE)); // R9
endmodule

// File: rtl/bus_repeater_switch.sv
`timescale 1ns/1ps
module bus_repeater_switch
    import brs_pkg::*;
#(
    parameter int NUM_CH = BRS_NUM_CH,
    parameter int CFG_W  = BRS_CFG_W,
    parameter int SYNC_N = BRS_SYNC_N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              up_clk_in,
    output logic              up_clk_pull,
    input  logic              up_dat_in,
    output logic              up_dat_pull,
    input  logic [NUM_CH-1:0] dn_clk_in,
    output logic [NUM_CH-1:0] dn_clk_pull,
    input  logic [NUM_CH-1:0] dn_dat_in,
    output logic [NUM_CH-1:0] dn_dat_pull
);
    localparam int SW = 2 * NUM_CH + 2;

    logic [CFG_W-1:0]  cfg_d, cfg_q;
    logic [NUM_CH-1:0] ch_en;
    logic              clk_rev;
    logic              cfg_unused;
    logic [SW-1:0]     lvl_raw, lvl_s;

    always_comb begin
        cfg_d = cfg_we ? cfg_wdata : cfg_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign ch_en      = cfg_q[NUM_CH-1:0];
    assign clk_rev    = cfg_q[CFG_W-1];
    assign cfg_unused = ^cfg_q[CFG_W-2:NUM_CH];

    assign lvl_raw = {up_clk_in, up_dat_in, dn_clk_in, dn_dat_in};

    brs_sync #(.WIDTH(SW), .STAGES(SYNC_N)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (lvl_raw),
        .dout (lvl_s)
    );

    brs_clk_route #(.NUM_CH(NUM_CH)) u_clk (
        .clk    (clk),
        .rst_n  (rst_n),
        .reverse(clk_rev),
        .en     (ch_en),
        .up_lvl (lvl_s[SW-1]),
        .dn_lvl (lvl_s[2*NUM_CH-1:NUM_CH]),
        .up_pull(up_clk_pull),
        .dn_pull(dn_clk_pull)
    );

    brs_dat_arbiter #(.NUM_CH(NUM_CH)) u_dat (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (ch_en),
        .up_lvl (lvl_s[SW-2]),
        .dn_lvl (lvl_s[NUM_CH-1:0]),
        .up_pull(up_dat_pull),
        .dn_pull(dn_dat_pull)
    );

    AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cfg_q == $past(cfg_wdata))); // R2
endmodule

// File: tb/bus_repeater_switch_test.sv
`timescale 1ns/1ps
module bus_repeater_switch_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       ext_up_clk = 1'b0, ext_up_dat = 1'b0;
    logic [3:0] ext_dn_clk = 4'h0, ext_dn_dat = 4'h0;
    logic       up_clk_in, up_dat_in, up_clk_pull, up_dat_pull;
    logic [3:0] dn_clk_in, dn_dat_in, dn_clk_pull, dn_dat_pull;

    int n_run = 0, n_fail = 0;
    bit cmp_on = 1'b0, done = 1'b0;

    always #2 clk = ~clk;

    // Wired-AND wires: low if either the outside world or the block sinks them.
    assign up_clk_in = ~(ext_up_clk | up_clk_pull);
    assign up_dat_in = ~(ext_up_dat | up_dat_pull);
    assign dn_clk_in = ~(ext_dn_clk | dn_clk_pull);
    assign dn_dat_in = ~(ext_dn_dat | dn_dat_pull);

    bus_repeater_switch uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .up_clk_in(up_clk_in), .up_clk_pull(up_clk_pull),
        .up_dat_in(up_dat_in), .up_dat_pull(up_dat_pull),
        .dn_clk_in(dn_clk_in), .dn_clk_pull(dn_clk_pull),
        .dn_dat_in(dn_dat_in), .dn_dat_pull(dn_dat_pull)
    );

    // Bench reference model, written from the requirements.
    logic [9:0] m_s1, m_s2, m_lvl;
    logic       m_pu, m_upc, m_upd, m_nupc, m_nupd, m_rev;
    logic [3:0] m_pd, m_dnc, m_dnd, m_ndnc, m_ndnd, m_en, m_fdn, m_dlv, m_clv;
    logic [7:0] m_cfg;
    int         m_side, m_idx, m_nside, m_nidx;

    function automatic logic [3:0] fwd_clk(logic rev, logic [3:0] en, logic up_lvl);
        return rev ? 4'h0 : (en & {4{~up_lvl}});
    endfunction

    function automatic logic rev_clk(logic rev, logic [3:0] en, logic [3:0] dn_lvl);
        return rev & (|(en & ~dn_lvl));
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 = '1; m_s2 = '1; m_pu = 1'b1; m_pd = '1; m_cfg = '0;
            m_side = 0; m_idx = 0; m_upc = 0; m_upd = 0; m_dnc = 0; m_dnd = 0;
        end else begin
            m_lvl = ~({ext_up_clk, ext_up_dat, ext_dn_clk, ext_dn_dat} | {m_upc, m_upd, m_dnc, m_dnd});
            m_en = m_cfg[3:0]; m_rev = m_cfg[7];
            m_clv = m_s2[7:4]; m_dlv = m_s2[3:0];
            m_ndnc = fwd_clk(m_rev, m_en, m_s2[9]);
            m_nupc = rev_clk(m_rev, m_en, m_clv);
            m_fdn = m_pd & ~m_dlv & m_en;
            m_nside = m_side; m_nidx = m_idx;
            if (m_side == 0) begin
                if (m_pu && !m_s2[8]) m_nside = 1;
                else for (int k = 0; k < 4; k++)
                    if (m_fdn[k] && m_nside == 0) begin m_nside = 2; m_nidx = k; end
            end else if (m_side == 1) begin
                if (m_s2[8]) m_nside = 0;
            end else if (m_dlv[m_idx] || !m_en[m_idx]) begin
                m_nside = 0;
            end
            m_nupd = (m_nside == 2);
            m_ndnd = (m_nside == 1) ? m_en : 4'h0;
            m_pu = m_s2[8]; m_pd = m_dlv;
            m_s2 = m_s1; m_s1 = m_lvl;
            if (cfg_we) m_cfg = cfg_wdata;
            m_side = m_nside; m_idx = m_nidx;
            m_upc = m_nupc; m_dnc = m_ndnc; m_upd = m_nupd; m_dnd = m_ndnd;
        end
    end

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            chk("R3 model dn_clk_pull", {4'h0, dn_clk_pull}, {4'h0, m_dnc});
            chk("R4 model up_clk_pull", {7'h0, up_clk_pull}, {7'h0, m_upc});
            chk("R6 model dn_dat_pull", {4'h0, dn_dat_pull}, {4'h0, m_dnd});
            chk("R7 model up_dat_pull", {7'h0, up_dat_pull}, {7'h0, m_upd});
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_cfg(logic [7:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        step(1);
        cfg_we = 1'b0;
        step(3);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        step(3);
        chk("R1 reset pulls", {up_clk_pull, up_dat_pull, dn_clk_pull[1:0], dn_dat_pull}, 8'h00);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        step(2);
        ext_up_clk = 1'b1; step(4);
        chk("R1 no channel enabled after reset", {4'h0, dn_clk_pull}, 8'h00);
        ext_up_clk = 1'b0; step(4);

        // Forward clock and latency
        wr_cfg(8'h0F);
        ext_up_clk = 1'b1; step(2);
        chk("R12 latency two edges", {4'h0, dn_clk_pull}, 8'h00);
        step(1);
        chk("R3 R2 forward clock", {4'h0, dn_clk_pull}, 8'h0F);
        chk("R3 up_clk_pull idle", {7'h0, up_clk_pull}, 8'h00);
        ext_up_clk = 1'b0; step(4);
        chk("R3 forward clock released", {4'h0, dn_clk_pull}, 8'h00);

        wr_cfg(8'h05);
        ext_up_clk = 1'b1; step(4);
        chk("R5 masked forward clock", {4'h0, dn_clk_pull}, 8'h05);
        ext_up_clk = 1'b0; step(4);

        // Reverse clock
        wr_cfg(8'h8F);
        ext_dn_clk = 4'b0100; step(4);
        chk("R4 reverse clock AND", {7'h0, up_clk_pull}, 8'h01);
        chk("R4 no downstream clock drive", {4'h0, dn_clk_pull}, 8'h00);
        ext_dn_clk = 4'h0; step(4);
        chk("R4 reverse released", {7'h0, up_clk_pull}, 8'h00);
        ext_up_clk = 1'b1; step(4);
        chk("R4 no stretch back", {4'h0, dn_clk_pull}, 8'h00);
        ext_up_clk = 1'b0; step(2);
        wr_cfg(8'h8B);
        ext_dn_clk = 4'b0100; step(4);
        chk("R11 disabled clock ignored", {7'h0, up_clk_pull}, 8'h00);
        ext_dn_clk = 4'h0; step(4);

        // Upstream wins data
        wr_cfg(8'h0F);
        ext_up_dat = 1'b1; step(2);
        chk("R12 data latency", {4'h0, dn_dat_pull}, 8'h00);
        step(1);
        chk("R6 upstream fall drives down", {4'h0, dn_dat_pull}, 8'h0F);
        chk("R6 upstream not pulled", {7'h0, up_dat_pull}, 8'h00);
        ext_up_dat = 1'b0; step(2);
        chk("R9 hold until third edge", {4'h0, dn_dat_pull}, 8'h0F);
        step(1);
        chk("R9 all release together", {4'h0, dn_dat_pull}, 8'h00);
        step(6);
        chk("R9 no self relatch", {3'h0, up_dat_pull, dn_dat_pull}, 8'h00);

        // Downstream wins data, then lockout
        ext_dn_dat = 4'b0100; step(3);
        chk("R7 downstream fall drives up", {7'h0, up_dat_pull}, 8'h01);
        chk("R7 no downstream drive", {4'h0, dn_dat_pull}, 8'h00);
        ext_dn_dat = 4'b0101; step(4);
        chk("R8 held with second fall", {3'h0, up_dat_pull, dn_dat_pull}, 8'h10);
        ext_dn_dat = 4'b0001; step(3);
        chk("R8 late low does not take over", {7'h0, up_dat_pull}, 8'h00);
        ext_dn_dat = 4'h0; step(6);

        // Same-cycle priority
        ext_up_dat = 1'b1; ext_dn_dat = 4'b0010; step(3);
        chk("R10 upstream beats downstream", {3'h0, up_dat_pull, dn_dat_pull}, 8'h0F);
        ext_up_dat = 1'b0; ext_dn_dat = 4'h0; step(6);
        ext_dn_dat = 4'b1001; step(3);
        chk("R10 channel 0 or 3 owns", {7'h0, up_dat_pull}, 8'h01);
        ext_dn_dat = 4'b1000; step(3);
        chk("R10 channel 0 was owner", {7'h0, up_dat_pull}, 8'h00);
        ext_dn_dat = 4'h0; step(6);

        // Disabled data channel
        wr_cfg(8'h0D);
        ext_dn_dat = 4'b0010; step(4);
        chk("R11 disabled data ignored", {7'h0, up_dat_pull}, 8'h00);
        ext_dn_dat = 4'h0; step(2);
        ext_up_dat = 1'b1; step(4);
        chk("R5 disabled data not pulled", {4'h0, dn_dat_pull}, 8'h0D);
        ext_up_dat = 1'b0; step(6);

        // Seeded random traffic, checked each cycle against the model
        for (int c = 0; c < 3000; c++) begin
            if (($urandom % 8) == 0) begin
                int b;
                b = $urandom % 10;
                if (b == 9)      ext_up_clk = ~ext_up_clk;
                else if (b == 8) ext_up_dat = ~ext_up_dat;
                else if (b >= 4) ext_dn_clk[b-4] = ~ext_dn_clk[b-4];
                else             ext_dn_dat[b] = ~ext_dn_dat[b];
            end
            if (($urandom % 64) == 0) begin
                cfg_we = 1'b1; cfg_wdata = 8'($urandom);
            end else begin
                cfg_we = 1'b0;
            end
            step(1);
        end
        cfg_we = 1'b0;
        step(2);
        done = 1'b1;
        finish_run();
    end
endmodule